// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block paces the external code and data bus of an 8-bit controller core. It runs on the oscillator clock and divides time into machine cycles of twelve clocks, numbered phase 0 to phase 11. Each machine cycle is one of five kinds: an internal fetch, an external fetch, an external data read, an external data write, or an external code-table read. The kind is chosen at the boundary between cycles. The block then produces the address-latch strobe (ALE), the active-low program-store strobe, and the active-low read and write strobes. It also drives the shared low address/data port and the high-address port.

A fetch cycle gives two ALE pulses. An external fetch also gives two program-store pulses, for bytes `addr` and `addr+1`. A data cycle keeps only the first ALE pulse. That pulse latches the data address. The read or write strobe then fills the span where the second ALE pulse and both program-store pulses would have been.

Requests for accesses arrive on a valid/ready channel. `req_ready` is high only in phase 11. A requester holds `req_valid` and its fields stable until the edge where both are high. That is the only back-pressure point, and at most one access is taken per machine cycle. Read results come out as a one-clock `rd_valid` pulse with no ready. The consumer must take the result in that clock.

Top module: `xbus_strobe_seq`

## Requirements
- R1: While `rst` is high, the cycle is held at phase 0 of an internal cycle. In that state `psen_n`, `rd_n` and `wr_n` are 1, `ad_oe` is 0 and `req_ready` is 0. `ale` is 0 when `ale_dis` is 0.
- R2: In fetch and code-read cycles, `ale` is 1 exactly in phases 1, 2, 7 and 8. Phases count 0..11 from the clock after the cycle boundary. This gives two pulses per machine cycle.
- R3: In data read and write cycles, `ale` is 1 only in phases 1 and 2, so the second pulse is dropped. `psen_n` stays 1 for the whole cycle.
- R4: In external fetch and code-read cycles, `psen_n` is 0 in phases 3–5 and 9–11. A fetch cycle is external when `code_int_en` is 0 or `pc >= 0x1000`. Otherwise it is internal, and `psen_n` stays 1.
- R5: In every external cycle, the port drives the low address byte in phases 0–2 (`ad_oe`=1). In fetch and code-read cycles it drives the low byte of `addr+1` in phases 6–8. In a write cycle it drives the write data in phases 3–11. In all other phases `ad_oe` is 0.
- R6: `hi_out` follows the kind of cycle:
  - Fetch cycles give the upper byte of the latched `pc`.
  - Code reads and wide data accesses (`req_wide`=1) give the upper byte of `dptr`.
  - Narrow data accesses give the `p2` value sampled at acceptance, with `ri` as the low byte.
  - Internal cycles give the live `p2`.
- R7: `rd_n` is 0 in phases 3–11 of a read cycle and `wr_n` is 0 in phases 3–11 of a write cycle. The two are never 0 together, and neither is 0 while `psen_n` is 0.
- R8: With `ale_dis`=1 and `code_int_en`=1, `ale` is held at 1 for all of an internal cycle. Data and code-read cycles still pulse as in R2 and R3.
- R9: With `code_int_en`=0, `ale_dis` has no effect, and fetch cycles pulse as in R2.
- R10: A request is taken on the edge where `req_valid` and `req_ready` are both high. The codes for `req_op` are 0 = data read, 1 = data write, 2 = code read, and 3 is treated as a data read. The next machine cycle is that access, built from the inputs sampled on that edge. With no request, the next cycle is a fetch at `pc`.
- R11: A data read captures `ad_in` on the phase-11 edge, and `rd_valid` is 1 for the one clock of the next phase 0. A code read captures on the phase-5 edge, and `rd_valid` is 1 for the clock of phase 6. `rd_data` holds the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| code_int_en | input | 1 | 1: low code range is internal; 0: all fetches external |
| ale_dis | input | 1 | Suppress ALE pulses in internal cycles |
| pc | input | 16 | Fetch address, sampled at the cycle boundary |
| dptr | input | 16 | Wide data / code-read address |
| ri | input | 8 | Narrow data address low byte |
| p2 | input | 8 | High-port register value |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted this clock (phase 11) |
| req_op | input | 2 | 0 read, 1 write, 2 code read, 3 read |
| req_wide | input | 1 | 1: address from `dptr`; 0: `{p2, ri}` |
| req_wdata | input | 8 | Write data |
| ad_in | input | 8 | Low port read-back from the pins |
| ad_out | output | 8 | Low port drive value |
| ad_oe | output | 1 | Low port drive enable |
| hi_out | output | 8 | High-address port |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 8 | Read result byte |

## Verification
All strobes and port drives are decoded from the registered phase and cycle kind, so each output changes one clock edge after the phase it belongs to. A request or a `pc` value held across the phase-11 edge shapes the next twelve clocks. The read result appears one edge after its capture edge, in phase 0 or phase 6.

The bench advances its own phase and kind model on every rising edge. It compares all outputs half a clock later, once the edge has settled. New stimulus is presented mid-cycle, so it is stable long before the boundary edge that samples it.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;
  localparam int unsigned PH_N = 12;
  localparam int unsigned PH_W = $clog2(PH_N);
  typedef logic [PH_W-1:0] ph_t;

  // phase landmarks within a machine cycle
  localparam ph_t PH_LAST   = ph_t'(PH_N - 1);
  localparam ph_t ALE_A_LO  = ph_t'(1);
  localparam ph_t ALE_A_HI  = ph_t'(2);
  localparam ph_t ALE_B_LO  = ph_t'(7);
  localparam ph_t ALE_B_HI  = ph_t'(8);
  localparam ph_t PS_A_LO   = ph_t'(3);
  localparam ph_t PS_A_HI   = ph_t'(5);
  localparam ph_t PS_B_LO   = ph_t'(9);
  localparam ph_t ADR_A_HI  = ph_t'(2);
  localparam ph_t ADR_B_LO  = ph_t'(6);
  localparam ph_t ADR_B_HI  = ph_t'(8);
  localparam ph_t STB_LO    = ph_t'(3);
  localparam ph_t CRD_CAP   = ph_t'(5);

  typedef enum logic [2:0] {
    K_INT, K_EXT, K_XRD, K_XWR, K_CRD
  } cyc_kind_t;

  localparam logic [1:0] OP_XWR = 2'd1;
  localparam logic [1:0] OP_CRD = 2'd2;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr
  import xbus_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  output ph_t  ph,
  output logic last
);
  assign last = (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= last ? '0 : ph + 1'b1;
  end
endmodule

// File: rtl/xbus_cycle_plan.sv
module xbus_cycle_plan
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned INT_TOP = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last,
  input  logic              code_int_en,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] ri,
  input  logic [ADDR_W-DATA_W-1:0] p2,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output cyc_kind_t         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);
  localparam logic [ADDR_W:0] TOP_V = (ADDR_W+1)'(INT_TOP);

  cyc_kind_t         nxt_kind;
  logic [ADDR_W-1:0] nxt_addr;
  logic              take;

  assign req_ready = last;
  assign take      = req_valid && last;

  always_comb begin
    if (take) begin
      if (req_op == OP_CRD) begin
        nxt_kind = K_CRD;
        nxt_addr = dptr;
      end else begin
        nxt_kind = (req_op == OP_XWR) ? K_XWR : K_XRD;
        nxt_addr = req_wide ? dptr : {p2, ri};
      end
    end else begin
      nxt_kind = (code_int_en && ({1'b0, pc} < TOP_V)) ? K_INT : K_EXT;
      nxt_addr = pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind  <= K_INT;
      addr  <= '0;
      wdata <= '0;
    end else if (last) begin
      kind  <= nxt_kind;
      addr  <= nxt_addr;
      wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ph_t               ph,
  input  cyc_kind_t         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-DATA_W-1:0] p2,
  input  logic              ale_dis,
  input  logic              code_int_en,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_out,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic              is_data, is_code, is_ext, stb;
  logic              in_ale_a, in_ale_b, in_ps, in_adr_a, in_adr_b;
  logic [DATA_W-1:0] next_lo;

  assign is_data  = (kind == K_XRD) || (kind == K_XWR);
  assign is_code  = (kind == K_EXT) || (kind == K_CRD);
  assign is_ext   = (kind != K_INT);
  assign stb      = (ph >= STB_LO);
  assign in_ale_a = (ph >= ALE_A_LO) && (ph <= ALE_A_HI);
  assign in_ale_b = (ph >= ALE_B_LO) && (ph <= ALE_B_HI);
  assign in_ps    = ((ph >= PS_A_LO) && (ph <= PS_A_HI)) || (ph >= PS_B_LO);
  assign in_adr_a = (ph <= ADR_A_HI);
  assign in_adr_b = (ph >= ADR_B_LO) && (ph <= ADR_B_HI);
  assign next_lo  = addr[DATA_W-1:0] + 1'b1;

  always_comb begin
    if (kind == K_INT && ale_dis && code_int_en) ale = 1'b1;
    else ale = in_ale_a || (in_ale_b && !is_data);
  end

  assign psen_n = !(is_code && in_ps);
  assign rd_n   = !((kind == K_XRD) && stb);
  assign wr_n   = !((kind == K_XWR) && stb);
  assign hi_out = (kind == K_INT) ? p2 : addr[ADDR_W-1:DATA_W];

  always_comb begin
    ad_out = '0;
    ad_oe  = 1'b0;
    if (is_ext && in_adr_a) begin
      ad_out = addr[DATA_W-1:0];
      ad_oe  = 1'b1;
    end else if (is_code && in_adr_b) begin
      ad_out = next_lo;
      ad_oe  = 1'b1;
    end else if (kind == K_XWR && stb) begin
      ad_out = wdata;
      ad_oe  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if ((kind == K_XRD && ph == PH_LAST) || (kind == K_CRD && ph == CRD_CAP)) begin
      rd_valid <= 1'b1;
      rd_data  <= ad_in;
    end else begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
  import xbus_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned INT_TOP = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_int_en,
  input  logic              ale_dis,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] dptr,
  input  logic [DATA_W-1:0] ri,
  input  logic [ADDR_W-DATA_W-1:0] p2,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_out,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  ph_t               ph;
  logic              last;
  cyc_kind_t         kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;

  xbus_phase_ctr u_ph (.clk(clk), .rst(rst), .ph(ph), .last(last));

  xbus_cycle_plan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_TOP(INT_TOP)) u_plan (
    .clk(clk), .rst(rst), .last(last), .code_int_en(code_int_en),
    .pc(pc), .dptr(dptr), .ri(ri), .p2(p2),
    .req_valid(req_valid), .req_op(req_op), .req_wide(req_wide),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .kind(kind), .addr(addr), .wdata(wdata)
  );

  xbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .ph(ph), .kind(kind), .addr(addr), .wdata(wdata),
    .p2(p2), .ale_dis(ale_dis), .code_int_en(code_int_en), .ad_in(ad_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/xbus_strobe_seq_chk.sv
module xbus_strobe_seq_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic req_ready,
  input logic rd_valid
);
  a_r7_rd_wr_excl: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));
  a_r7_no_psen_with_stb: assert property (@(posedge clk) disable iff (rst) (!rd_n || !wr_n) |-> psen_n);
  a_r2_ale_two_clocks: assert property (@(posedge clk) disable iff (rst) $rose(ale) |=> ale);
  a_r4_psen_after_ale: assert property (@(posedge clk) disable iff (rst) $fell(psen_n) |-> $past(ale));
  a_r5_float_on_read: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe);
  a_r5_drive_on_write: assert property (@(posedge clk) disable iff (rst) !wr_n |-> ad_oe);
  a_r10_ready_single: assert property (@(posedge clk) disable iff (rst) req_ready |=> !req_ready);
  a_r11_valid_single: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid);
endmodule

bind xbus_strobe_seq xbus_strobe_seq_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .req_ready(req_ready), .rd_valid(rd_valid)
);

// File: tb/test_xbus_strobe_seq.sv
module test_xbus_strobe_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       code_int_en = 1'b1, ale_dis = 1'b0;
  logic [15:0] pc = 16'h0000, dptr = 16'h0000;
  logic [7:0] ri = 8'h00, p2 = 8'h00;
  logic       req_valid = 1'b0, req_wide = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_wdata = 8'h00, ad_in = 8'h00;
  logic       req_ready, ad_oe, ale, psen_n, rd_n, wr_n, rd_valid;
  logic [7:0] ad_out, hi_out, rd_data;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // model state: kinds 0 int, 1 ext fetch, 2 read, 3 write, 4 code read
  int m_ph = 0, m_kind = 0, m_addr = 0, m_wd = 0, m_rdv = 0, m_rdd = 0;

  always #4 clk = ~clk;

  xbus_strobe_seq i_xbus_strobe_seq (
    .clk(clk), .rst(rst), .code_int_en(code_int_en), .ale_dis(ale_dis),
    .pc(pc), .dptr(dptr), .ri(ri), .p2(p2), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_wide(req_wide),
    .req_wdata(req_wdata), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .hi_out(hi_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s t=%0t ph=%0d kind=%0d actual=%0h expected=%0h", tag, $time, m_ph, m_kind, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ph = 0; m_kind = 0; m_addr = 0; m_wd = 0; m_rdv = 0; m_rdd = 0;
    end else begin
      if ((m_kind == 2 && m_ph == 11) || (m_kind == 4 && m_ph == 5)) begin
        m_rdv = 1; m_rdd = ad_in;
      end else m_rdv = 0;
      if (m_ph == 11) begin
        if (req_valid) begin
          if (req_op == 2) begin m_kind = 4; m_addr = dptr; end
          else begin
            m_kind = (req_op == 1) ? 3 : 2;
            m_addr = req_wide ? dptr : {p2, ri};
          end
          m_wd = req_wdata;
        end else begin
          m_kind = (code_int_en && pc < 16'h1000) ? 0 : 1;
          m_addr = pc;
          m_wd = req_wdata;
        end
      end
      m_ph = (m_ph + 1) % 12;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst) begin
      chk("R1 ale", ale, 0); chk("R1 psen_n", psen_n, 1);
      chk("R1 rd_n", rd_n, 1); chk("R1 wr_n", wr_n, 1);
      chk("R1 ad_oe", ad_oe, 0); chk("R1 req_ready", req_ready, 0);
    end else if (!done) begin
      int e_ale, e_ps, e_oe, e_out, e_hi;
      bit data, code;
      string atag;
      data = (m_kind == 2 || m_kind == 3);
      code = (m_kind == 1 || m_kind == 4);
      // ale
      if (m_kind == 0 && ale_dis && code_int_en) begin e_ale = 1; atag = "R8 ale"; end
      else begin
        e_ale = (m_ph == 1 || m_ph == 2 || (!data && (m_ph == 7 || m_ph == 8))) ? 1 : 0;
        atag = data ? "R3 ale" : (ale_dis && !code_int_en) ? "R9 ale" : "R2 ale";
      end
      chk(atag, ale, e_ale);
      e_ps = (code && ((m_ph >= 3 && m_ph <= 5) || m_ph >= 9)) ? 0 : 1;
      chk(data ? "R3 psen_n" : "R4 psen_n", psen_n, e_ps);
      chk("R7 rd_n", rd_n, (m_kind == 2 && m_ph >= 3) ? 0 : 1);
      chk("R7 wr_n", wr_n, (m_kind == 3 && m_ph >= 3) ? 0 : 1);
      e_oe = 0; e_out = 0;
      if (m_kind != 0 && m_ph <= 2) begin e_oe = 1; e_out = m_addr % 256; end
      else if (code && m_ph >= 6 && m_ph <= 8) begin e_oe = 1; e_out = (m_addr + 1) % 256; end
      else if (m_kind == 3 && m_ph >= 3) begin e_oe = 1; e_out = m_wd; end
      chk("R5 ad_oe", ad_oe, e_oe);
      chk("R5 ad_out", ad_out, e_out);
      e_hi = (m_kind == 0) ? p2 : (m_addr / 256);
      chk("R6 hi_out", hi_out, e_hi);
      chk("R10 req_ready", req_ready, (m_ph == 11) ? 1 : 0);
      chk("R11 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk("R11 rd_data", rd_data, m_rdd);
    end
  end

  // present next cycle's inputs in mid-cycle
  task automatic next_cycle(input bit cie, input bit dis, input logic [15:0] p,
                            input bit v, input logic [1:0] op, input bit wide,
                            input logic [15:0] dp, input logic [7:0] r, input logic [7:0] hp,
                            input logic [7:0] wd, input logic [7:0] din);
    while (m_ph != 6) @(negedge clk);
    code_int_en = cie; ale_dis = dis; pc = p; req_valid = v; req_op = op;
    req_wide = wide; dptr = dp; ri = r; p2 = hp; req_wdata = wd; ad_in = din;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    next_cycle(1, 0, 16'h0100, 0, 0, 0, 0, 0, 8'h11, 0, 0);          // R4 internal
    next_cycle(1, 0, 16'h1234, 0, 0, 0, 0, 0, 8'h22, 0, 0);          // R4 ext above range
    next_cycle(0, 0, 16'h00FF, 0, 0, 0, 0, 0, 8'h22, 0, 0);          // R4 all external, R5 wrap
    next_cycle(1, 0, 16'h0100, 1, 0, 1, 16'hBEEF, 0, 8'h33, 0, 8'hA5); // R3 R11 wide read
    next_cycle(1, 0, 16'h0100, 1, 1, 0, 16'hBEEF, 8'h44, 8'h9C, 8'h3C, 0); // R6 narrow write
    next_cycle(1, 0, 16'h0100, 1, 3, 0, 0, 8'h81, 8'h5E, 0, 8'h7E);  // R10 op 3 as read
    next_cycle(1, 0, 16'h0100, 1, 2, 0, 16'h0FFE, 0, 8'h12, 0, 8'h66); // R11 code read
    next_cycle(1, 1, 16'h0010, 0, 0, 0, 0, 0, 8'h47, 0, 0);          // R8 held high
    next_cycle(1, 1, 16'h0010, 1, 1, 1, 16'h2345, 0, 8'h47, 8'hC3, 0); // R8 data still pulses
    next_cycle(0, 1, 16'h0010, 0, 0, 0, 0, 0, 8'h47, 0, 0);          // R9 ignored
    next_cycle(1, 0, 16'h0FFF, 0, 0, 0, 0, 0, 8'h58, 0, 0);          // R4 last internal
    next_cycle(1, 0, 16'h1000, 0, 0, 0, 0, 0, 8'h69, 0, 0);          // R4 first external
    next_cycle(1, 0, 16'h0200, 0, 0, 0, 0, 0, 8'hF0, 0, 0);
    next_cycle(1, 0, 16'h0200, 0, 0, 0, 0, 0, 8'h0F, 0, 0);          // R6 live p2
    repeat (14) @(negedge clk);
    done = 1;
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 5000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule